// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for each beat of one memory burst. When a read or write command strobe is accepted, it captures a starting column, a burst length code and an ordering bit. From the next cycle it presents one column address per beat. It moves to the next beat on every cycle where the beat enable is high, and it stops after the final beat.

The addresses never leave an aligned block whose size equals the burst length. The column bits above log2(length) come from the start column and do not change during the burst. The low bits begin at the start offset and wrap inside the block. They follow one of two orders:

- Linear order: the offset plus the beat index, modulo the length.
- Interleaved order: the offset XOR the beat index.

The same captured settings serve read bursts and write bursts alike. A command issued during the final beat, in the same cycle that beat is taken, starts the next burst with no idle cycle.

Top module: `burst_col_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the block is cleared. After that edge `valid_o` and `last_o` are 0.
- R2: A command (`cmd_i`=1) accepted while idle gives `valid_o`=1 in the following cycle, with `col_o` equal to the captured `start_col_i`.
- R3: During a burst, the column bits at and above log2(length) stay equal to the same bits of the captured start column. This includes the bits above bit 3, which are fixed for every length.
- R4: When `ilv_i`=0, beat i carries low bits equal to (offset + i) mod length. For example, length 8 from offset 5 gives 5,6,7,0,1,2,3,4.
- R5: When `ilv_i`=1, beat i carries low bits equal to offset XOR i. For example, length 8 from offset 5 gives 5,4,7,6,1,0,3,2.
- R6: `len_i` encodes the length as 00=2, 01=4, 10=8 and 11=16 beats. A burst presents exactly that many addresses, and `last_o` is high with the final one only.
- R7: While `beat_en_i`=0 during a burst, `valid_o` stays high and `col_o` holds its value.
- R8: A command that arrives during a burst is ignored, unless the final beat is taken in that same cycle. The running sequence continues unchanged.
- R9: A command that arrives in the cycle where the final beat is taken (`last_o`=1 and `beat_en_i`=1) starts the new burst in the next cycle. `valid_o` stays high and `col_o` shows the new start column.
- R10: Once the final beat is taken with no new command, `valid_o` falls in the next cycle. Inputs that change after capture do not affect the running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_i | input | 1 | Read or write command strobe |
| start_col_i | input | COL_W | Starting column address |
| len_i | input | 2 | Burst length code |
| ilv_i | input | 1 | Ordering: 0 linear, 1 interleaved |
| beat_en_i | input | 1 | Advance to the next beat |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | A beat is being presented |
| last_o | output | 1 | Current beat is the final one |

## Verification
A corrupted beat counter or captured offset shows up at once on `col_o`, in the same cycle, as a wrong low field. It can also place `last_o` on the wrong beat, which shortens or stretches the burst by the length of the error. A corrupted captured block base shows up as upper bits that differ from the start column on every beat of the burst. A wrong command-acceptance decision shows one cycle after the strobe: the sequence jumps mid-burst, or `valid_o` drops between two back-to-back bursts.

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int COL_W = 9,
  localparam int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [1:0]       len_i,
  input  logic             ilv_i,
  input  logic             beat_en_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);

  logic [COL_W-1:0] base_q;
  logic [1:0]       len_q;
  logic             ilv_q;
  logic [IDX_W-1:0] idx_q;
  logic             valid_q;
  logic [IDX_W-1:0] mask;
  logic [IDX_W-1:0] off;
  logic [IDX_W-1:0] low;
  logic             accept;

  always_comb begin
    case (len_q)
      2'b00:   mask = 4'b0001;
      2'b01:   mask = 4'b0011;
      2'b10:   mask = 4'b0111;
      default: mask = 4'b1111;
    endcase
  end

  assign off     = base_q[IDX_W-1:0] & mask;
  assign low     = (ilv_q ? (off ^ idx_q) : (off + idx_q)) & mask;
  assign col_o   = {base_q[COL_W-1:IDX_W], (base_q[IDX_W-1:0] & ~mask) | low};
  assign valid_o = valid_q;
  assign last_o  = valid_q && (idx_q == mask);
  assign accept  = cmd_i && (!valid_q || (beat_en_i && last_o));

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
    end else if (accept) begin
      valid_q <= 1'b1;
      idx_q   <= '0;
    end else if (valid_q && beat_en_i) begin
      if (last_o) begin
        valid_q <= 1'b0;
        idx_q   <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      base_q <= start_col_i;
      len_q  <= len_i;
      ilv_q  <= ilv_i;
    end
  end

endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_i,
  input logic [COL_W-1:0] start_col_i,
  input logic             beat_en_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o
);

  p_idle_start_r2: assert property (@(posedge clk) disable iff (rst)
    (!valid_o && cmd_i) |=> (valid_o && col_o == $past(start_col_i)));

  p_upper_fixed_r3: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !last_o && !cmd_i) |=> (valid_o && col_o[COL_W-1:4] == $past(col_o[COL_W-1:4])));

  p_last_needs_valid_r6: assert property (@(posedge clk) disable iff (rst)
    last_o |-> valid_o);

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !beat_en_i) |=> (valid_o && $stable(col_o)));

  p_chain_r9: assert property (@(posedge clk) disable iff (rst)
    (last_o && beat_en_i && cmd_i) |=> (valid_o && col_o == $past(start_col_i)));

  p_drop_r10: assert property (@(posedge clk) disable iff (rst)
    (last_o && beat_en_i && !cmd_i) |=> !valid_o);

endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rst(rst), .cmd_i(cmd_i), .start_col_i(start_col_i),
  .beat_en_i(beat_en_i), .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
);

// File: tb/tb_burst_col_seq.sv
module tb_burst_col_seq;
  localparam int COL_W = 9;
  localparam int NV = 10;
  // {ilv, len, start, expected final address}
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 2'b10, 9'h0D5, 9'h0D4},
    {1'b1, 2'b10, 9'h0D5, 9'h0D2},
    {1'b0, 2'b00, 9'h1FF, 9'h1FE},
    {1'b1, 2'b00, 9'h1FF, 9'h1FE},
    {1'b0, 2'b01, 9'h0A6, 9'h0A5},
    {1'b1, 2'b01, 9'h0A6, 9'h0A5},
    {1'b0, 2'b11, 9'h13B, 9'h13A},
    {1'b1, 2'b11, 9'h13B, 9'h134},
    {1'b0, 2'b11, 9'h100, 9'h10F},
    {1'b1, 2'b10, 9'h007, 9'h000}
  };

  logic clk = 1'b0, rst = 1'b1, cmd_i = 1'b0, ilv_i = 1'b0, beat_en_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [1:0] len_i = 2'b00;
  logic [COL_W-1:0] col_o;
  logic valid_o, last_o;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) dut (
    .clk(clk), .rst(rst), .cmd_i(cmd_i), .start_col_i(start_col_i),
    .len_i(len_i), .ilv_i(ilv_i), .beat_en_i(beat_en_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int expect_col(input int start, input int len, input bit ilv, input int i);
    int bl = 2 << len;
    int off = start & (bl - 1);
    int lo = ilv ? (off ^ i) : ((off + i) % bl);
    return (start & ~(bl - 1)) | lo;
  endfunction

  task automatic issue(input int start, input int len, input bit ilv);
    cmd_i = 1'b1; start_col_i = start[COL_W-1:0]; len_i = len[1:0]; ilv_i = ilv;
    @(negedge clk);
    cmd_i = 1'b0; start_col_i = 9'h155; len_i = ~len[1:0]; ilv_i = ~ilv;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid after reset", valid_o, 0);
    chk("R1 last after reset", last_o, 0);
    rst = 1'b0;
    beat_en_i = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      int st, ln, bl, fin; bit il;
      il = VEC[v][20]; ln = VEC[v][19:18]; st = VEC[v][17:9]; fin = VEC[v][8:0];
      bl = 2 << ln;
      issue(st, ln, il);
      for (int i = 0; i < bl; i++) begin
        chk(i == 0 ? "R2 first beat" : (il ? "R5 interleaved beat" : "R4 linear beat"),
            col_o, expect_col(st, ln, il, i));
        chk("R3 upper bits fixed", col_o >> (ln + 1), st >> (ln + 1));
        chk("R6 last flag", last_o, i == bl - 1);
        if (i == bl - 1) chk("R6 final address", col_o, fin);
        @(negedge clk);
      end
      chk("R10 valid drops", valid_o, 0);
    end

    // R7 stall
    issue(9'h020, 1, 1'b0);
    beat_en_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 hold col", col_o, 9'h020);
    chk("R7 hold valid", valid_o, 1);
    beat_en_i = 1'b1;
    @(negedge clk);
    chk("R7 resume", col_o, 9'h021);
    @(negedge clk); @(negedge clk);
    // last beat stalled with a command: ignored (R8)
    beat_en_i = 1'b0; cmd_i = 1'b1; start_col_i = 9'h1C0;
    @(negedge clk);
    cmd_i = 1'b0;
    chk("R8 cmd ignored on stalled last", col_o, 9'h023);
    chk("R8 last still high", last_o, 1);
    beat_en_i = 1'b1;
    @(negedge clk);
    chk("R10 valid drops after stall", valid_o, 0);

    // R8 mid-burst command ignored
    issue(9'h040, 2, 1'b0);
    @(negedge clk); @(negedge clk);
    cmd_i = 1'b1; start_col_i = 9'h1FF; len_i = 2'b00; ilv_i = 1'b1;
    @(negedge clk);
    cmd_i = 1'b0;
    for (int i = 3; i < 8; i++) begin
      chk("R8 sequence unchanged", col_o, 9'h040 + i);
      @(negedge clk);
    end
    chk("R8 burst ended", valid_o, 0);

    // R9 back-to-back
    issue(9'h010, 0, 1'b0);
    chk("R9 first of short", col_o, 9'h010);
    @(negedge clk);
    chk("R9 last of short", last_o, 1);
    issue(9'h0F2, 1, 1'b1);
    chk("R9 no gap valid", valid_o, 1);
    chk("R9 new start", col_o, 9'h0F2);
    @(negedge clk);
    chk("R9 R5 second beat", col_o, 9'h0F3);
    @(negedge clk);
    chk("R9 R5 third beat", col_o, 9'h0F0);
    @(negedge clk);
    chk("R9 R5 fourth beat", col_o, 9'h0F1);
    chk("R9 last of new", last_o, 1);
    @(negedge clk);
    chk("R10 idle after chain", valid_o, 0);

    // R1 reset mid-burst
    issue(9'h0AA, 3, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 reset clears valid", valid_o, 0);
    chk("R1 reset clears last", last_o, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule